// File: doc/BRIEF.md
# UART Receive Status and Interrupt Logic

This block is the receive half of the register and interrupt logic of a 16550-style UART. A deserializer hands it one character at a time, each tagged with parity-error, framing-error and break flags. Characters and their flags are kept in a 16-entry receive FIFO. A small CPU bus with a 3-bit address gives access to the receive holding register, the interrupt enable register, the interrupt identification register and the line status register. An active-high interrupt line is driven from three prioritised sources: receiver line status, received data available and character timeout.

A character that arrives with an error is still written into the FIFO. While its error condition is latched, the identification register reports a line status interrupt, even though data is waiting. A driver clears that condition by reading the line status register. Line status bit 7 shows that an errored character is still somewhere in the FIFO, so the driver then knows to drain the data. If the driver never reads the line status register, the interrupt stays asserted.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the identification register (address 2) reads 0xC1, the line status register (address 5) reads 0x00, the enable register (address 1) reads 0x00 and irq is low.
- R2: Received characters are stored in arrival order, up to 16. A read of address 0 returns the oldest stored character and removes it. Line status bit 0 is 1 exactly while the FIFO holds a character. A character that arrives in the same cycle as a removal is stored.
- R3: A character that arrives while the FIFO holds 16 characters, with no removal in that cycle, is discarded and sets line status bit 1 (overrun). The stored characters are unchanged.
- R4: A character with its parity, framing or break flag set is still stored. It sets line status bit 2, bit 3 or bit 4 respectively.
- R5: A read of the line status register clears bits 1 to 4. An error or overrun that arrives in the same cycle as that read remains set afterwards.
- R6: Line status bit 7 is 1 while at least one stored character carries an error flag. It returns to 0 once the last such character has been read out.
- R7: While any of line status bits 1 to 4 is set and enable bit 2 is 1, the identification register reads 0xC6. Reads of other registers, including the identification register itself, do not clear it.
- R8: With no line status interrupt, at least 4 stored characters and enable bit 0 set, the identification register reads 0xC4.
- R9: With the FIFO non-empty and fewer than 4 characters stored, the identification register reads 0xCC (timeout) once 4 char_tick pulses have passed with no store and no removal. A store or a removal restarts the count, and a read of address 0 clears the timeout.
- R10: A write to address 1 keeps bits 0 and 2 and reads back with all other bits 0. A disabled source is not reported in the identification register and does not raise irq, but its line status bits still show.
- R11: irq is high exactly when the identification register bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Character has a parity error |
| rx_ferr | input | 1 | Character has a framing error |
| rx_brk | input | 1 | Character is a break |
| char_tick | input | 1 | One pulse per character time |
| cpu_addr | input | 3 | Register address |
| cpu_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two events can fall in the same cycle: a line status read, which clears the latched error bits, and the arrival of a new errored character, which sets one of them. The bench drives both strobes at the same falling edge. It checks that the value read back shows the state before the edge, and that a second line status read then shows the new framing bit together with bit 7. The same approach covers a removal and an arrival in one cycle: the bench checks that the FIFO holds exactly the new character afterwards.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DEPTH    = 16,
  parameter int TRIG     = 4,
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       char_tick,
  input  logic [2:0] cpu_addr,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TO_CHARS + 1);

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, ecnt;
  logic [TW-1:0] tcnt;
  logic [7:0]    ier;
  logic          oe, pe, fe, bi;

  logic rd_rhr, rd_lsr, wr_ier, pop, push, full, ovr, in_err, top_err;
  logic ls_pend, rda, to_hit;
  logic [10:0] top;
  logic [7:0]  lsr, iir;

  assign rd_rhr  = cpu_rd && cpu_addr == 3'd0;
  assign rd_lsr  = cpu_rd && cpu_addr == 3'd5;
  assign wr_ier  = cpu_wr && cpu_addr == 3'd1;
  assign full    = cnt == CW'(DEPTH);
  assign pop     = rd_rhr && cnt != '0;
  assign push    = rx_valid && (!full || pop);
  assign ovr     = rx_valid && full && !pop;
  assign in_err  = rx_perr | rx_ferr | rx_brk;
  assign top     = mem[rp];
  assign top_err = |top[10:8];

  always_ff @(posedge clk)
    if (push) mem[wp] <= {rx_perr, rx_ferr, rx_brk, rx_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      ecnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
      if ((push && in_err) && !(pop && top_err))      ecnt <= ecnt + 1'b1;
      else if (!(push && in_err) && (pop && top_err)) ecnt <= ecnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oe <= 1'b0;
      pe <= 1'b0;
      fe <= 1'b0;
      bi <= 1'b0;
    end else begin
      oe <= (oe && !rd_lsr) || ovr;
      pe <= (pe && !rd_lsr) || (push && rx_perr);
      fe <= (fe && !rd_lsr) || (push && rx_ferr);
      bi <= (bi && !rd_lsr) || (push && rx_brk);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         tcnt <= '0;
    else if (push || pop || cnt == '0)  tcnt <= '0;
    else if (char_tick && tcnt != TW'(TO_CHARS)) tcnt <= tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ier <= '0;
    else if (wr_ier) ier <= cpu_wdata & 8'h05;

  assign ls_pend = oe | pe | fe | bi;
  assign rda     = cnt >= CW'(TRIG);
  assign to_hit  = cnt != '0 && tcnt == TW'(TO_CHARS);
  assign lsr     = {ecnt != '0, 2'b00, bi, fe, pe, oe, cnt != '0};

  always_comb begin
    if (ls_pend && ier[2])     iir = 8'hC6;
    else if (rda && ier[0])    iir = 8'hC4;
    else if (to_hit && ier[0]) iir = 8'hCC;
    else                       iir = 8'hC1;
  end

  assign irq = !iir[0];

  always_comb
    case (cpu_addr)
      3'd0:    cpu_rdata = top[7:0];
      3'd1:    cpu_rdata = ier;
      3'd2:    cpu_rdata = iir;
      3'd5:    cpu_rdata = lsr;
      default: cpu_rdata = 8'h00;
    endcase

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R3
  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !rd_rhr) |=> (oe && cnt == $past(cnt))); // R3
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rx_valid) |=> cnt == $past(cnt) - 1'b1); // R2
  AST_ERR_IN_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= cnt); // R6
  AST_LS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_pend && ier[2] && !rd_lsr && !wr_ier) |=> irq); // R7
endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, char_tick = 0;
  logic [7:0] rx_data = 0, cpu_wdata = 0;
  logic [2:0] cpu_addr = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  uart_rx_status u_dut (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .char_tick(char_tick),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq(irq));

  // op nibble 7 (0 push, 1 read, 2 write, 3 ticks), addr nibble 6,
  // flags nibble 5 (4 parity, 2 framing, 1 break), requirement nibble 4, data byte 1, expect byte 0
  localparam int NV = 40;
  localparam logic [31:0] VEC [NV] = '{
    32'h1201_00C1, 32'h1501_0000, 32'h1101_0000, 32'h210A_0500, 32'h110A_0005,
    32'h0002_4100, 32'h1502_0001, 32'h1209_00C1, 32'h3009_0400, 32'h1209_00CC,
    32'h1002_0041, 32'h1209_00C1, 32'h0024_5500, 32'h1207_00C6, 32'h1207_00C6,
    32'h1504_0089, 32'h1205_00C1, 32'h1506_0081, 32'h1002_0055, 32'h1506_0000,
    32'h0002_0100, 32'h0002_0200, 32'h0002_0300, 32'h1208_00C1, 32'h0002_0400,
    32'h1208_00C4, 32'h0044_0500, 32'h1207_00C6, 32'h1504_0085, 32'h1208_00C4,
    32'h210A_0000, 32'h120A_00C1, 32'h150A_0081, 32'h210A_0500, 32'h1002_0001,
    32'h1002_0002, 32'h1002_0003, 32'h1002_0004, 32'h1002_0005, 32'h1506_0000
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] f);
    @(negedge clk);
    rx_valid = 1; rx_data = d; {rx_perr, rx_ferr, rx_brk} = f;
    @(negedge clk);
    rx_valid = 0; {rx_perr, rx_ferr, rx_brk} = 3'b000;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1;
    #2 v = cpu_rdata;
    @(negedge clk);
    cpu_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); char_tick = 1;
      @(negedge clk); char_tick = 0;
    end
  endtask

  task automatic expect_rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    #2 check("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1;

    for (int k = 0; k < NV; k++) begin
      logic [31:0] e;
      string req;
      e = VEC[k];
      req = $sformatf("R%0d vec %0d", e[19:16], k);
      case (e[31:28])
        4'd0: push(e[15:8], e[22:20]);
        4'd2: wr(e[26:24], e[15:8]);
        4'd3: ticks(int'(e[15:8]));
        default: begin
          rd(e[26:24], v);
          check(req, v, e[7:0]);
          if (e[26:24] == 3'd2) check("R11 irq vs id", {7'd0, irq}, {7'd0, ~e[0]});
        end
      endcase
    end

    // R3 overrun at full FIFO
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 3'b000);
    push(8'hEE, 3'b000);
    expect_rd("R3 overrun id", 3'd2, 8'hC6);
    expect_rd("R3 overrun lsr", 3'd5, 8'h03);
    expect_rd("R5 lsr cleared", 3'd5, 8'h01);
    expect_rd("R8 full id", 3'd2, 8'hC4);
    for (int i = 0; i < 16; i++) expect_rd("R3 contents", 3'd0, 8'h10 + 8'(i));
    expect_rd("R2 drained", 3'd5, 8'h00);

    // R4 break flag
    push(8'h00, 3'b001);
    expect_rd("R4 break lsr", 3'd5, 8'h91);
    expect_rd("R4 break char", 3'd0, 8'h00);
    expect_rd("R6 bit7 gone", 3'd5, 8'h00);

    // R5 clear and set in the same cycle
    @(negedge clk);
    cpu_addr = 3'd5; cpu_rd = 1;
    rx_valid = 1; rx_data = 8'h77; rx_ferr = 1;
    #2 check("R5 read before edge", cpu_rdata, 8'h00);
    @(negedge clk);
    cpu_rd = 0; rx_valid = 0; rx_ferr = 0;
    expect_rd("R5 new error kept", 3'd5, 8'h89);
    expect_rd("R5 char", 3'd0, 8'h77);
    expect_rd("R5 empty", 3'd5, 8'h00);

    // R2 push and pop in one cycle
    push(8'h11, 3'b000);
    @(negedge clk);
    cpu_addr = 3'd0; cpu_rd = 1; rx_valid = 1; rx_data = 8'h22;
    #2 check("R2 same cycle old", cpu_rdata, 8'h11);
    @(negedge clk);
    cpu_rd = 0; rx_valid = 0;
    expect_rd("R2 one left", 3'd5, 8'h01);
    expect_rd("R2 new char", 3'd0, 8'h22);
    expect_rd("R2 empty", 3'd5, 8'h00);

    // R9 timeout restart on store, clear on read
    push(8'hA1, 3'b000);
    ticks(3);
    push(8'hA2, 3'b000);
    ticks(3);
    expect_rd("R9 restarted", 3'd2, 8'hC1);
    ticks(1);
    #2 check("R11 irq on timeout", {7'd0, irq}, 8'h01);
    expect_rd("R9 timeout", 3'd2, 8'hCC);
    expect_rd("R9 read char", 3'd0, 8'hA1);
    expect_rd("R9 cleared", 3'd2, 8'hC1);
    #2 check("R11 irq low", {7'd0, irq}, 8'h00);
    expect_rd("R9 last char", 3'd0, 8'hA2);

    // R10 line status disabled keeps irq low
    wr(3'd1, 8'hFF);
    expect_rd("R10 readback", 3'd1, 8'h05);
    wr(3'd1, 8'h01);
    push(8'h33, 3'b010);
    #2 check("R10 no irq", {7'd0, irq}, 8'h00);
    expect_rd("R10 lsr shows", 3'd5, 8'h89);
    expect_rd("R10 char", 3'd0, 8'h33);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule